// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit virtual address into a physical address. It reads two entries of a page table held in memory. A request carries the virtual address and an access kind: read, write or execute. The walker first compares the top index against a length register. If the index passes, it reads a directory entry at the location held in the base register. It then reads the leaf entry from the table that the directory entry points to. Last, it checks the leaf's valid, permission and dirty bits. The outcome leaves on a response channel as a physical address or a fault code.

Requests and responses use valid/ready streams, and only one translation is in flight at a time. `req_ready` is high only while the walker is idle. Once raised, `rsp_valid` holds, with its payload stable, until `rsp_ready` takes it. On the memory side, the request channel is valid/ready. A raised `mem_req_valid` holds its address, data and direction until `mem_req_ready`. A read returns exactly one `mem_rsp_valid` pulse, which cannot be stalled. A write needs no response. Software loads the base and length registers through a plain one-cycle write port.

Top module: `xlat_walker`

## Requirements
- R1: After reset `req_ready` is high, `rsp_valid` and `mem_req_valid` are low, and the base and length registers hold zero.
- R2: A request is accepted when `req_valid` and `req_ready` are both high. `req_ready` stays low from acceptance until the response is taken, and at most one of `req_ready`, `mem_req_valid` and `rsp_valid` is high in any cycle.
- R3: The directory entry is read at base + 4 × vaddr[31:22]. The leaf entry is read at {directory entry bits 31:12, 12'h000} + 4 × vaddr[21:12].
- R4: On success `rsp_fault` is 0 and `rsp_paddr` is {leaf bits 31:12, vaddr[11:0]}. On any fault `rsp_paddr` is 0.
- R5: If vaddr[31:22] is at or above the length register, the response has fault 1 and the walker makes no memory access. This includes an index exactly equal to the length.
- R6: A directory entry with bit 0 (valid) clear gives fault 2 after exactly one memory read.
- R7: A leaf entry with bit 0 clear gives fault 3, whatever its other bits.
- R8: The access kind is encoded 0 read, 1 write, 2 execute and 3 reserved. A valid leaf permits the access only if bit 1 (read), bit 2 (write) or bit 3 (execute) matches the kind. Kind 3 is never permitted. A denied access gives fault 4.
- R9: A permitted write whose leaf has bit 4 (dirty) clear writes the leaf back to its own address with bit 4 set before the response, making three memory accesses in all. A leaf with bit 4 already set is not written.
- R10: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_paddr` and `rsp_fault` hold their values.
- R11: While `mem_req_valid` is high and `mem_req_ready` is low, the request holds its address, direction and write data.
- R12: When `cfg_we` is high, `cfg_sel` 0 writes `cfg_wdata` to the base register and `cfg_sel` 1 writes `cfg_wdata[10:0]` to the length register. A requests accepted after the write uses the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 0 read, 1 write, 2 execute, 3 reserved |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_fault | output | 3 | 0 none, 1 bounds, 2 directory invalid, 3 leaf invalid, 4 permission |
| mem_req_valid | output | 1 | Memory access request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 write, 0 read |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_req_wdata | output | 32 | Entry value to write |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Entry read from memory |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 base register, 1 length register |
| cfg_wdata | input | 32 | Register write value |

## Verification
The dirty write-back is the hardest case to reach from the ports. It needs a valid directory entry, a leaf that grants write with its dirty bit clear, and a write request. Its proof is a third memory access and a changed memory word. The bench builds such a leaf and counts memory handshakes for each translation. It then reads the memory word back and repeats the write, which must now take only two accesses. The bench also stalls `mem_req_ready` in a repeating pattern, so every walk crosses memory back-pressure. It holds `rsp_ready` low on one response to stall the output side.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int ENT_VALID = 0;
  localparam int ENT_RD    = 1;
  localparam int ENT_WR    = 2;
  localparam int ENT_EX    = 3;
  localparam int ENT_DIRTY = 4;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [2:0] {
    FLT_NONE   = 3'd0,
    FLT_BOUNDS = 3'd1,
    FLT_DIR    = 3'd2,
    FLT_LEAF   = 3'd3,
    FLT_PERM   = 3'd4
  } fault_e;
endpackage

// File: rtl/xlat_cfg.sv
module xlat_cfg #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] base_o,
  output logic [LEN_W-1:0]  len_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_o <= '0;
      len_o  <= '0;
    end else if (cfg_we) begin
      if (cfg_sel) len_o  <= cfg_wdata[LEN_W-1:0];
      else         base_o <= cfg_wdata;
    end
  end
endmodule

// File: rtl/xlat_perm.sv
module xlat_perm
  import xlat_pkg::*;
#(
  parameter int ENT_W = 32
) (
  input  logic [ENT_W-1:0] entry_i,
  input  acc_e             kind_i,
  output fault_e           fault_o,
  output logic             need_dirty_o
);
  logic allowed;

  always_comb begin
    unique case (kind_i)
      ACC_READ:  allowed = entry_i[ENT_RD];
      ACC_WRITE: allowed = entry_i[ENT_WR];
      ACC_EXEC:  allowed = entry_i[ENT_EX];
      default:   allowed = 1'b0;
    endcase
    if (!entry_i[ENT_VALID])  fault_o = FLT_LEAF;
    else if (!allowed)        fault_o = FLT_PERM;
    else                      fault_o = FLT_NONE;
    need_dirty_o = entry_i[ENT_VALID] && allowed && (kind_i == ACC_WRITE)
                   && !entry_i[ENT_DIRTY];
  end
endmodule

// File: rtl/xlat_fsm.sv
module xlat_fsm
  import xlat_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 12,
  parameter int IDX_W  = 10,
  parameter int LEN_W  = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  acc_e              req_kind,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_paddr,
  output fault_e            rsp_fault,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [ADDR_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [LEN_W-1:0]  len_i
);
  localparam int FRM_W   = ADDR_W - OFS_W;
  localparam int DIR_LSB = OFS_W + IDX_W;

  typedef enum logic [2:0] {
    S_IDLE, S_DIR_REQ, S_DIR_WAIT, S_LEAF_REQ, S_LEAF_WAIT, S_DIRTY_REQ, S_RESP
  } st_e;

  st_e               state;
  logic [ADDR_W-1:0] vaddr_q;
  acc_e              kind_q;
  logic [ADDR_W-1:0] dir_addr_q;
  logic [FRM_W-1:0]  tbl_frame_q;
  logic [ADDR_W-1:0] leaf_q;
  logic [ADDR_W-1:0] paddr_q;
  fault_e            fault_q;

  logic [IDX_W-1:0]  dir_idx;
  logic [IDX_W-1:0]  leaf_idx_q;
  logic              out_of_range;
  logic [ADDR_W-1:0] leaf_addr;
  fault_e            leaf_fault;
  logic              need_dirty;

  assign dir_idx      = req_vaddr[ADDR_W-1:DIR_LSB];
  assign leaf_idx_q   = vaddr_q[DIR_LSB-1:OFS_W];
  assign out_of_range = {1'b0, dir_idx} >= len_i;
  assign leaf_addr    = {tbl_frame_q, {OFS_W{1'b0}}} + ADDR_W'({leaf_idx_q, 2'b00});

  xlat_perm #(.ENT_W(ADDR_W)) u_perm (
    .entry_i      (mem_rsp_data),
    .kind_i       (kind_q),
    .fault_o      (leaf_fault),
    .need_dirty_o (need_dirty)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      vaddr_q     <= '0;
      kind_q      <= ACC_READ;
      dir_addr_q  <= '0;
      tbl_frame_q <= '0;
      leaf_q      <= '0;
      paddr_q     <= '0;
      fault_q     <= FLT_NONE;
    end else begin
      unique case (state)
        S_IDLE: if (req_valid) begin
          vaddr_q    <= req_vaddr;
          kind_q     <= req_kind;
          dir_addr_q <= base_i + ADDR_W'({dir_idx, 2'b00});
          if (out_of_range) begin
            fault_q <= FLT_BOUNDS;
            paddr_q <= '0;
            state   <= S_RESP;
          end else begin
            state <= S_DIR_REQ;
          end
        end
        S_DIR_REQ: if (mem_req_ready) state <= S_DIR_WAIT;
        S_DIR_WAIT: if (mem_rsp_valid) begin
          if (!mem_rsp_data[ENT_VALID]) begin
            fault_q <= FLT_DIR;
            paddr_q <= '0;
            state   <= S_RESP;
          end else begin
            tbl_frame_q <= mem_rsp_data[ADDR_W-1:OFS_W];
            state       <= S_LEAF_REQ;
          end
        end
        S_LEAF_REQ: if (mem_req_ready) state <= S_LEAF_WAIT;
        S_LEAF_WAIT: if (mem_rsp_valid) begin
          leaf_q <= mem_rsp_data;
          if (leaf_fault != FLT_NONE) begin
            fault_q <= leaf_fault;
            paddr_q <= '0;
            state   <= S_RESP;
          end else begin
            fault_q <= FLT_NONE;
            paddr_q <= {mem_rsp_data[ADDR_W-1:OFS_W], vaddr_q[OFS_W-1:0]};
            state   <= need_dirty ? S_DIRTY_REQ : S_RESP;
          end
        end
        S_DIRTY_REQ: if (mem_req_ready) state <= S_RESP;
        S_RESP: if (rsp_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    req_ready     = (state == S_IDLE);
    rsp_valid     = (state == S_RESP);
    rsp_paddr     = paddr_q;
    rsp_fault     = fault_q;
    mem_req_valid = (state == S_DIR_REQ) || (state == S_LEAF_REQ) || (state == S_DIRTY_REQ);
    mem_req_write = (state == S_DIRTY_REQ);
    mem_req_addr  = (state == S_DIR_REQ) ? dir_addr_q : leaf_addr;
    mem_req_wdata = leaf_q | (ADDR_W'(1) << ENT_DIRTY);
  end

  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault));

  assert_mem_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_write) && $stable(mem_req_wdata));

  assert_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_ready, mem_req_valid, rsp_valid}));

  assert_dirty_kind_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_write |-> kind_q == ACC_WRITE && leaf_q[ENT_WR]);

  assert_bounds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && out_of_range |=> rsp_valid && rsp_fault == FLT_BOUNDS);
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xlat_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 12,
  parameter int IDX_W  = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_vaddr,
  input  logic [1:0]  req_kind,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [31:0] rsp_paddr,
  output logic [2:0]  rsp_fault,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic        mem_req_write,
  output logic [31:0] mem_req_addr,
  output logic [31:0] mem_req_wdata,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data,
  input  logic        cfg_we,
  input  logic        cfg_sel,
  input  logic [31:0] cfg_wdata
);
  localparam int LEN_W = IDX_W + 1;

  logic [ADDR_W-1:0] base_w;
  logic [LEN_W-1:0]  len_w;
  fault_e            fault_w;

  xlat_cfg #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .base_o    (base_w),
    .len_o     (len_w)
  );

  xlat_fsm #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vaddr     (req_vaddr),
    .req_kind      (acc_e'(req_kind)),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_paddr     (rsp_paddr),
    .rsp_fault     (fault_w),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .base_i        (base_w),
    .len_i         (len_w)
  );

  assign rsp_fault = fault_w;
endmodule

// File: tb/test_xlat_walker.sv
module test_xlat_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_kind = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_paddr;
  logic [2:0]  rsp_fault;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic        mem_req_write;
  logic [31:0] mem_req_addr;
  logic [31:0] mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        cfg_we = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0;

  int n_chk = 0;
  int n_bad = 0;
  int acc_cnt = 0;
  int cyc = 0;
  logic [31:0] mem [0:4095];

  always #5 clk = ~clk;

  xlat_walker i_xlat_walker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_kind(req_kind), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata)
  );

  // behavioural memory, stalls one cycle in four
  assign mem_req_ready = (cyc[1:0] != 2'd1);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      acc_cnt <= acc_cnt + 1;
      if (mem_req_write) mem[mem_req_addr[13:2]] <= mem_req_wdata;
      else begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mem[mem_req_addr[13:2]];
      end
    end
  end

  task automatic fin();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  always @(posedge clk) if (cyc > 20000) begin
    n_chk = n_chk + 1;
    n_bad = n_bad + 1;
    $display("FAIL watchdog act=%0d exp=<20000", cyc);
    fin();
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic sel, input logic [31:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic xlat(input logic [31:0] va, input logic [1:0] k,
                      output logic [31:0] pa, output logic [2:0] f, output int n);
    int start;
    int t;
    @(negedge clk);
    chk("R2 idle ready", 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_vaddr = va; req_kind = k;
    start = acc_cnt;
    @(negedge clk);
    req_valid = 1'b0;
    t = 0;
    while (!rsp_valid && t < 300) begin
      chk("R2 busy not ready", 32'(req_ready), 32'd0);
      @(negedge clk);
      t++;
    end
    pa = rsp_paddr; f = rsp_fault; n = acc_cnt - start;
  endtask

  typedef struct packed {
    logic [31:0] va;
    logic [1:0]  kind;
    logic [2:0]  flt;
    logic [31:0] pa;
    logic [1:0]  nacc;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0ABC, 2'd0, 3'd0, 32'hABCD_EABC, 2'd2},
    '{32'h0000_0123, 2'd1, 3'd4, 32'h0,         2'd2},
    '{32'h0000_2FFF, 2'd2, 3'd0, 32'h5555_5FFF, 2'd2},
    '{32'h0000_2000, 2'd0, 3'd4, 32'h0,         2'd2},
    '{32'h0000_3000, 2'd0, 3'd3, 32'h0,         2'd2},
    '{32'h0040_0000, 2'd0, 3'd2, 32'h0,         2'd1},
    '{32'h0100_0000, 2'd0, 3'd1, 32'h0,         2'd0},
    '{32'hFFC0_0000, 2'd2, 3'd1, 32'h0,         2'd0},
    '{32'h0000_4010, 2'd1, 3'd0, 32'h3333_3010, 2'd2},
    '{32'h0000_1456, 2'd1, 3'd0, 32'h1234_5456, 2'd3},
    '{32'h0000_1000, 2'd1, 3'd0, 32'h1234_5000, 2'd2},
    '{32'h0080_5444, 2'd2, 3'd0, 32'hFEDC_B444, 2'd2},
    '{32'h0000_0000, 2'd3, 3'd4, 32'h0,         2'd2}
  };

  initial begin
    logic [31:0] pa;
    logic [2:0] f;
    int n;
    for (int i = 0; i < 4096; i++) mem[i] <= 32'h0;
    @(negedge clk);
    mem[12'h040] <= 32'h0000_1001;  // dir 0 -> table at 0x1000
    mem[12'h042] <= 32'h0000_2001;  // dir 2 -> table at 0x2000
    mem[12'h400] <= 32'hABCD_E003;  // read only
    mem[12'h401] <= 32'h1234_5007;  // read/write, clean
    mem[12'h402] <= 32'h5555_5009;  // execute only
    mem[12'h403] <= 32'h7777_701E;  // not valid
    mem[12'h404] <= 32'h3333_3017;  // read/write, dirty
    mem[12'h805] <= 32'hFEDC_B00F;  // read/write/execute
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 req_ready", 32'(req_ready), 32'd1);
    chk("R1 rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R1 mem_req_valid", 32'(mem_req_valid), 32'd0);

    // length resets to zero: every index is out of range
    xlat(32'h0000_0ABC, 2'd0, pa, f, n);
    chk("R1 R5 reset length fault", 32'(f), 32'd1);
    chk("R5 no access", 32'(n), 32'd0);

    cfg_write(1'b0, 32'h0000_0100);
    cfg_write(1'b1, 32'h0000_0004);

    for (int i = 0; i < NV; i++) begin
      xlat(VECS[i].va, VECS[i].kind, pa, f, n);
      chk("R3 R4 paddr", pa, VECS[i].pa);
      chk("R5 R6 R7 R8 fault", 32'(f), 32'(VECS[i].flt));
      chk("R5 R6 R9 access count", 32'(n), 32'(VECS[i].nacc));
      if (i == 9) chk("R9 dirty written back", mem[12'h401], 32'h1234_5017);
    end
    chk("R9 dirty leaf untouched", mem[12'h404], 32'h3333_3017);

    // length boundary: index equal to length faults
    cfg_write(1'b1, 32'h0000_0003);
    xlat(32'h0080_5444, 2'd0, pa, f, n);
    chk("R12 below new length", pa, 32'hFEDC_B444);
    xlat(32'h00C0_0000, 2'd0, pa, f, n);
    chk("R5 R12 index equals length", 32'(f), 32'd1);
    chk("R5 boundary no access", 32'(n), 32'd0);

    // moved base: empty directory there
    cfg_write(1'b0, 32'h0000_0200);
    xlat(32'h0000_0ABC, 2'd0, pa, f, n);
    chk("R12 R6 new base dir fault", 32'(f), 32'd2);
    chk("R6 one read", 32'(n), 32'd1);
    cfg_write(1'b0, 32'h0000_0100);

    // response back-pressure
    rsp_ready = 1'b0;
    xlat(32'h0000_2ABC, 2'd2, pa, f, n);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R10 rsp held", 32'(rsp_valid), 32'd1);
      chk("R10 paddr stable", rsp_paddr, 32'h5555_5ABC);
      chk("R2 not ready while held", 32'(req_ready), 32'd0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R10 released", 32'(rsp_valid), 32'd0);
    chk("R2 ready after take", 32'(req_ready), 32'd1);
    fin();
  end
endmodule